// File: doc/BRIEF.md
# Dual-Channel UART Control and Status Registers

This block is the register front end for a two-channel UART, seen from a byte-wide memory-mapped bus. Each channel has a 32-byte window with four word-spaced registers. The first register is a mode location that reaches two mode registers through a pointer that advances by itself. The second register reads back status and takes the clock-select byte when written. The third is a write-only command register. The fourth reads received data and takes transmit data when written.

The serial shifters, FIFOs and baud generator sit outside this block and connect to it through flag, event and strobe ports. A command write is decoded into a receiver reset strobe, a transmitter reset strobe, a pointer rewind, a break request, and independent receiver and transmitter enables. The mode registers drive the character length, the parity settings and the stop-bit setting. Error events from the receiver are held in the status byte until software resets the receiver.

Top module: `duart_chan_regs`

## Requirements
- R1: After reset, both channels have their receiver and transmitter disabled and no break requested. Both mode registers and the clock-select byte read 0, the mode pointer selects mode register 1, and `par_en` is 1 (the mode-1 parity field is 0).
- R2: Command-register bits (offset 0x08) act as follows. Bit 0 enables the receiver and bit 1 disables it. Bit 2 enables the transmitter and bit 3 disables it. When the enable bit and the disable bit of one direction are both set, the disable wins. When neither is set, that enable keeps its value.
- R3: Command opcode 2 (bits [6:4]) resets the receiver. It clears the receiver enable, even if bit 0 is set in the same write. It clears the four sticky error bits. It pulses `rx_rst` for one cycle.
- R4: Command opcode 3 resets the transmitter. It clears the transmitter enable and the break request, and it pulses `tx_rst` for one cycle.
- R5: Opcode 6 sets the break request and opcode 7 clears it. The break request holds its value between these commands. The enable bits in a break command still take effect.
- R6: Writes to offset 0x00 go first to mode register 1, and every later write goes to mode register 2. Opcode 1 rewinds the pointer to mode register 1. A read of offset 0x00 returns the mode register the pointer currently selects.
- R7: In mode register 1, bits [1:0] give `char_len`, where codes 0 to 3 mean 5 to 8 data bits. Bit 2 gives `par_odd`. `par_en` is 0 exactly when bits [4:3] equal 2.
- R8: `two_stop` follows bit 3 of mode register 2 (0x0F means two stop bits and 0x07 means one).
- R9: A read of offset 0x04 returns the status byte. Its bits are: 7 break, 6 framing error, 5 parity error, 4 overrun, 3 `tx_empty`, 2 `tx_rdy`, 1 always 0, 0 `rx_rdy`.
- R10: A pulse on an error-event input sets the matching status bit. The bit stays set until a receiver reset.
- R11: Channel 1 uses the same offsets plus 0x20 and is fully independent of channel 0. A write with address bit 4 set, or with address bits [1:0] nonzero, changes nothing.
- R12: A write to offset 0x04 loads that channel's byte of `clk_sel`. A read of offset 0x04 still returns status.
- R13: A write to offset 0x0C puts the byte on `tx_byte` and pulses that channel's `tx_wr` bit for one cycle.
- R14: A read of offset 0x0C returns that channel's byte of `rx_data` and raises that channel's `rx_pop` bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address; bit 5 selects the channel |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| rx_rdy | input | 2 | Receiver holds a character, per channel |
| tx_rdy | input | 2 | Transmitter accepts a character, per channel |
| tx_empty | input | 2 | Transmitter fully idle, per channel |
| rx_brk_evt | input | 2 | Break detected event |
| rx_frm_evt | input | 2 | Framing error event |
| rx_par_evt | input | 2 | Parity error event |
| rx_ovr_evt | input | 2 | Overrun event |
| rx_data | input | 16 | Received byte, channel 1 in [15:8] |
| rx_pop | output | 2 | Received byte consumed |
| tx_wr | output | 2 | Transmit byte strobe |
| tx_byte | output | 8 | Last transmit byte written |
| rx_en | output | 2 | Receiver enabled |
| tx_en | output | 2 | Transmitter enabled |
| rx_rst | output | 2 | Receiver reset pulse |
| tx_rst | output | 2 | Transmitter reset pulse |
| brk_req | output | 2 | Break request |
| char_len | output | 4 | Character-length code, 2 bits per channel |
| par_en | output | 2 | Parity enabled |
| par_odd | output | 2 | Odd parity |
| two_stop | output | 2 | Two stop bits |
| clk_sel | output | 16 | Clock-select byte, channel 1 in [15:8] |

## Verification
The bench sends a command with both the enable bit and the disable bit set; a design that lets the enable win leaves the receiver running. It sends a receiver reset together with a receiver enable; a design that ignores the precedence re-enables the receiver, and a design that forgets the sticky errors still reports them afterwards. It writes the mode location three times, rewinds and writes again; a pointer that wraps, or that does not rewind, corrupts the character length or the stop-bit setting. It also checks that break survives idle cycles, that status and clock select share an offset without aliasing, and that the two channels and the unused offsets do not disturb each other.

// File: rtl/duart_chan_regs.sv
module duart_chan_regs #(
  parameter int CH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      bus_addr,
  input  logic            bus_we,
  input  logic            bus_re,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [CH-1:0]   rx_rdy,
  input  logic [CH-1:0]   tx_rdy,
  input  logic [CH-1:0]   tx_empty,
  input  logic [CH-1:0]   rx_brk_evt,
  input  logic [CH-1:0]   rx_frm_evt,
  input  logic [CH-1:0]   rx_par_evt,
  input  logic [CH-1:0]   rx_ovr_evt,
  input  logic [8*CH-1:0] rx_data,
  output logic [CH-1:0]   rx_pop,
  output logic [CH-1:0]   tx_wr,
  output logic [7:0]      tx_byte,
  output logic [CH-1:0]   rx_en,
  output logic [CH-1:0]   tx_en,
  output logic [CH-1:0]   rx_rst,
  output logic [CH-1:0]   tx_rst,
  output logic [CH-1:0]   brk_req,
  output logic [2*CH-1:0] char_len,
  output logic [CH-1:0]   par_en,
  output logic [CH-1:0]   par_odd,
  output logic [CH-1:0]   two_stop,
  output logic [8*CH-1:0] clk_sel
);
  localparam logic [1:0] OFF_MODE = 2'd0, OFF_STAT = 2'd1, OFF_CMD = 2'd2, OFF_DATA = 2'd3;
  localparam logic [2:0] OP_PTR = 3'd1, OP_RXR = 3'd2, OP_TXR = 3'd3, OP_BON = 3'd6, OP_BOFF = 3'd7;

  logic       hit;
  logic [1:0] off;
  logic       chs;
  logic [CH-1:0][7:0] mode_view, stat_view;

  assign hit = !bus_addr[4] && (bus_addr[1:0] == 2'b00);
  assign off = bus_addr[3:2];
  assign chs = bus_addr[5];

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic       sel, cmd_w;
    logic [2:0] opc;
    logic [7:0] mr1_q, mr2_q, csr_q;
    logic       ptr_q, rxe_q, txe_q, brk_q, rxr_q, txr_q, twr_q;
    logic [3:0] err_q;

    assign sel   = bus_we && hit && (chs == 1'(g));
    assign cmd_w = sel && (off == OFF_CMD);
    assign opc   = bus_wdata[6:4];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mr1_q <= '0; mr2_q <= '0; csr_q <= '0; err_q <= '0;
        ptr_q <= 1'b0; rxe_q <= 1'b0; txe_q <= 1'b0; brk_q <= 1'b0;
        rxr_q <= 1'b0; txr_q <= 1'b0; twr_q <= 1'b0;
      end else begin
        rxr_q <= cmd_w && (opc == OP_RXR);
        txr_q <= cmd_w && (opc == OP_TXR);
        twr_q <= sel && (off == OFF_DATA);
        if (sel && off == OFF_MODE) begin
          if (ptr_q) mr2_q <= bus_wdata;
          else       mr1_q <= bus_wdata;
          ptr_q <= 1'b1;
        end
        if (sel && off == OFF_STAT) csr_q <= bus_wdata;
        if (cmd_w && opc == OP_RXR)
          err_q <= '0;
        else
          err_q <= err_q | {rx_brk_evt[g], rx_frm_evt[g], rx_par_evt[g], rx_ovr_evt[g]};
        if (cmd_w) begin
          if (opc == OP_PTR) ptr_q <= 1'b0;
          if (opc == OP_RXR || bus_wdata[1]) rxe_q <= 1'b0;
          else if (bus_wdata[0])             rxe_q <= 1'b1;
          if (opc == OP_TXR || bus_wdata[3]) txe_q <= 1'b0;
          else if (bus_wdata[2])             txe_q <= 1'b1;
          if (opc == OP_TXR || opc == OP_BOFF) brk_q <= 1'b0;
          else if (opc == OP_BON)              brk_q <= 1'b1;
        end
      end
    end

    assign mode_view[g]      = ptr_q ? mr2_q : mr1_q;
    assign stat_view[g]      = {err_q, tx_empty[g], tx_rdy[g], 1'b0, rx_rdy[g]};
    assign rx_en[g]          = rxe_q;
    assign tx_en[g]          = txe_q;
    assign rx_rst[g]         = rxr_q;
    assign tx_rst[g]         = txr_q;
    assign tx_wr[g]          = twr_q;
    assign brk_req[g]        = brk_q;
    assign char_len[2*g +: 2] = mr1_q[1:0];
    assign par_odd[g]        = mr1_q[2];
    assign par_en[g]         = (mr1_q[4:3] != 2'b10);
    assign two_stop[g]       = mr2_q[3];
    assign clk_sel[8*g +: 8] = csr_q;
    assign rx_pop[g]         = bus_re && hit && (chs == 1'(g)) && (off == OFF_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_byte <= '0;
    else if (bus_we && hit && off == OFF_DATA) tx_byte <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (off)
        OFF_MODE: bus_rdata = mode_view[chs];
        OFF_STAT: bus_rdata = stat_view[chs];
        OFF_DATA: bus_rdata = rx_data[8*chs +: 8];
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/duart_chan_regs_chk.sv
module duart_chan_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] bus_addr,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [1:0] rx_pop,
  input logic [1:0] tx_wr,
  input logic [7:0] tx_byte,
  input logic [1:0] rx_en,
  input logic [1:0] tx_en,
  input logic [1:0] rx_rst,
  input logic [1:0] tx_rst,
  input logic [1:0] brk_req,
  input logic [15:0] clk_sel
);
  logic cmd0, cmd1;
  assign cmd0 = bus_we && bus_addr == 6'h08;
  assign cmd1 = bus_we && bus_addr == 6'h28;

  p_dis_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd0 && bus_wdata[1] |=> !rx_en[0]);
  p_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd0 && bus_wdata[0] && !bus_wdata[1] && bus_wdata[6:4] != 3'd2 |=> rx_en[0]);
  p_rx_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd0 && bus_wdata[6:4] == 3'd2 |=> rx_rst[0] && !rx_en[0]);
  p_tx_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd1 && bus_wdata[6:4] == 3'd3 |=> tx_rst[1] && !tx_en[1] && !brk_req[1]);
  p_brk_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd0 && bus_wdata[6:4] == 3'd6 |=> brk_req[0]);
  p_brk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req[0] && !cmd0 |=> brk_req[0]);
  p_clksel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 6'h04 |=> clk_sel[7:0] == $past(bus_wdata));
  p_txwr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == 6'h0C |=> tx_wr[0] && tx_byte == $past(bus_wdata));
  p_pop_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_pop));
endmodule

bind duart_chan_regs duart_chan_regs_chk u_chk (.*);

// File: tb/duart_chan_regs_tb.sv
module duart_chan_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [1:0] rx_rdy = '0, tx_rdy = '0, tx_empty = '0;
  logic [1:0] rx_brk_evt = '0, rx_frm_evt = '0, rx_par_evt = '0, rx_ovr_evt = '0;
  logic [15:0] rx_data = 16'hA53C;
  logic [1:0] rx_pop, tx_wr, rx_en, tx_en, rx_rst, tx_rst, brk_req, par_en, par_odd, two_stop;
  logic [7:0] tx_byte;
  logic [3:0] char_len;
  logic [15:0] clk_sel;

  always #4 clk = ~clk;

  duart_chan_regs u_dut (.*);

  typedef struct { string tag; int what; logic [15:0] exp; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  function automatic logic [15:0] observe(int w);
    case (w)
      0: return {8'h0, bus_rdata};
      1: return {14'h0, rx_en};
      2: return {14'h0, tx_en};
      3: return {14'h0, brk_req};
      4: return {14'h0, rx_rst};
      5: return {14'h0, tx_rst};
      6: return {12'h0, char_len};
      7: return {14'h0, par_en};
      8: return {14'h0, par_odd};
      9: return {14'h0, two_stop};
      10: return clk_sel;
      11: return {14'h0, tx_wr};
      12: return {8'h0, tx_byte};
      default: return {14'h0, rx_pop};
    endcase
  endfunction

  always begin
    @(posedge clk); #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (observe(it.what) !== it.exp) begin
        errors++;
        $display("FAIL %s item %0d actual %h expected %h", it.tag, it.what, observe(it.what), it.exp);
      end
    end
  end

  task automatic exp(string tag, int what, logic [15:0] v);
    item_t it;
    it.tag = tag; it.what = what; it.exp = v;
    q.push_back(it);
  endtask
  task automatic put(logic [5:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
  endtask
  task automatic get(logic [5:0] a);
    bus_addr = a; bus_re = 1'b1;
  endtask
  task automatic step();
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    rx_brk_evt = '0; rx_frm_evt = '0; rx_par_evt = '0; rx_ovr_evt = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    get(6'h00);
    exp("R1", 0, 16'h00); exp("R1", 1, 0); exp("R1", 2, 0); exp("R1", 3, 0);
    exp("R1", 6, 0); exp("R1", 7, 16'h3); exp("R1", 9, 0); exp("R1", 10, 0);
    step();
    // R2 enable and disable bits
    put(6'h08, 8'h05); exp("R2", 1, 16'h1); exp("R2", 2, 16'h1); step();
    put(6'h08, 8'h03); exp("R2", 1, 16'h0); exp("R2", 2, 16'h1); step();
    put(6'h08, 8'h01); exp("R2", 1, 16'h1); step();
    // R6 R7 R8 mode pointer and decode
    put(6'h00, 8'h13); exp("R7", 6, 16'h3); exp("R7", 7, 16'h2); exp("R7", 8, 16'h0); step();
    put(6'h00, 8'h0F); exp("R8", 9, 16'h1); exp("R6", 6, 16'h3); step();
    put(6'h00, 8'h07); exp("R6", 9, 16'h0); exp("R6", 6, 16'h3); step();
    get(6'h00); exp("R6", 0, 16'h07); step();
    put(6'h08, 8'h10); step();
    get(6'h00); exp("R6", 0, 16'h13); step();
    put(6'h00, 8'h06); exp("R7", 6, 16'h2); exp("R7", 8, 16'h1); exp("R7", 7, 16'h3);
    exp("R6", 9, 16'h0); step();
    get(6'h00); exp("R6", 0, 16'h07); step();
    // R12 R9 clock select and status share an offset
    put(6'h04, 8'hBB); exp("R12", 10, 16'h00BB); step();
    rx_rdy = 2'b01; tx_rdy = 2'b01; tx_empty = 2'b01;
    get(6'h04); exp("R9", 0, 16'h0D); step();
    // R10 sticky errors, R3 receiver reset
    rx_par_evt = 2'b01; rx_ovr_evt = 2'b01; step();
    get(6'h04); exp("R10", 0, 16'h3D); step();
    get(6'h04); exp("R10", 0, 16'h3D); step();
    put(6'h08, 8'h21); exp("R3", 1, 16'h0); exp("R3", 4, 16'h1); step();
    get(6'h04); exp("R3", 0, 16'h0D); exp("R3", 4, 16'h0); step();
    rx_brk_evt = 2'b01; rx_frm_evt = 2'b01; step();
    get(6'h04); exp("R10", 0, 16'hCD); step();
    // R5 break
    put(6'h08, 8'h60); exp("R5", 3, 16'h1); step();
    step(); exp("R5", 3, 16'h1); step();
    put(6'h08, 8'h70); exp("R5", 3, 16'h0); step();
    put(6'h08, 8'h64); exp("R5", 3, 16'h1); exp("R5", 2, 16'h1); step();
    // R4 transmitter reset
    put(6'h08, 8'h30); exp("R4", 3, 16'h0); exp("R4", 2, 16'h0); exp("R4", 5, 16'h1); step();
    exp("R4", 5, 16'h0); step();
    // R11 second channel and ignored addresses
    put(6'h28, 8'h05); exp("R11", 1, 16'h2); exp("R11", 2, 16'h2); step();
    put(6'h20, 8'h02); exp("R11", 6, 16'hA); step();
    put(6'h24, 8'hCC); exp("R11", 10, 16'hCCBB); step();
    put(6'h10, 8'hFF); step();
    put(6'h05, 8'hFF); exp("R11", 10, 16'hCCBB); step();
    put(6'h19, 8'h11); exp("R11", 1, 16'h2); exp("R11", 6, 16'hA); step();
    // R13 transmit strobe
    put(6'h2C, 8'h5A); exp("R13", 11, 16'h2); exp("R13", 12, 16'h5A); step();
    exp("R13", 11, 16'h0); step();
    // R14 receive read
    get(6'h0C); exp("R14", 0, 16'h3C); exp("R14", 13, 16'h1); step();
    get(6'h2C); exp("R14", 0, 16'hA5); exp("R14", 13, 16'h2); step();
    step(); step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule